// File: doc/BRIEF.md
# Flash burst program-verify sequencer

This block programs a short burst of flash words, then checks them and retries until they are correct. Software loads the target words into the block's data registers while it is idle. It then gives a start pulse with the burst length, the base word address and the retry limit.

The sequencer can first read the words in normal mode. Any bit that already holds its programmed value is then masked off. After that it runs passes. In each pass it pulses every word that still has pending bits. It then switches the flash into its stricter program-verify read mode and reads the words back. The flash confirms each mode change through a status acknowledge, and the read wait states follow the mode. Each read updates the working word with the bits that reached their target. The flash is then returned to normal read mode.

The burst ends in success once every word reads all ones. It ends in failure when pending bits remain and the retry limit has been used up. On either outcome the block raises a completion flag, and it can also give a one-cycle interrupt pulse.

Top module: `flash_burst_prog_seq`

## Requirements
- R1: Data words are written through `ld_en`/`ld_idx`/`ld_word`, and `start` is accepted, only while the sequencer is idle. While a burst runs, both are ignored and the burst finishes with the values it started with.
- R2: After every read of word i, the working word becomes `W | ~(F | W)`, where W is the working word and F is the flash data. A program pulse (`fl_prog`, one cycle, `fl_wdata` = working word) is issued only for a word that is not all ones. A 0 bit in `fl_wdata` is programmed.
- R3: When `pre_check_en` is high at start, every burst word is read in normal mode and merged before the first pulse. If all words are then all ones, the burst completes successfully with no pulse.
- R4: Before a verify read-back, `fl_ws` is set to `ws_verify`, and in a later cycle `fl_vfy_req` is set to the bank mask. `fl_rd` is not raised until `fl_vfy_ack` equals `fl_vfy_req`. Each word is sampled once `fl_rd` has been held at its address for `fl_ws`+1 cycles.
- R5: After the verify reads, `fl_vfy_req` returns to 0. Once `fl_vfy_ack` is 0, `fl_ws` returns to `ws_normal`. Pulses are only issued while request and acknowledge are both 0.
- R6: Passes are counted. At each check the burst succeeds if all words are all ones. It fails if the pass count equals `max_pulses` (a limit of 0 fails without any pulse). Otherwise another pass starts, so each word receives at most `max_pulses` pulses.
- R7: The `fl_vfy_req` bank mask has bit 0 set if the first or last burst address is below `bank_limit`, and bit 1 set if either is at or above it.
- R8: `done` goes high at completion and stays high until the next accepted start. `error` is high with `done` on failure and is cleared at start. `irq` pulses for one cycle at completion when `irq_en` is high.
- R9: After reset, `done`, `error`, `irq`, `fl_prog`, `fl_rd` and `fl_vfy_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write a burst data word |
| ld_idx | input | 2 | Index of the data word to write |
| ld_word | input | 32 | Target data word |
| start | input | 1 | Start a burst |
| burst_len | input | 2 | Number of words minus one |
| base_addr | input | 16 | Word address of the first burst word |
| pre_check_en | input | 1 | Read and mask before the first pass |
| max_pulses | input | 4 | Maximum number of program passes |
| ws_normal | input | 4 | Wait states in normal read mode |
| ws_verify | input | 4 | Wait states in program-verify mode |
| bank_limit | input | 16 | First word address of the upper bank |
| irq_en | input | 1 | Enable the completion interrupt pulse |
| fl_addr | output | 16 | Flash word address |
| fl_wdata | output | 32 | Flash program data |
| fl_prog | output | 1 | Program pulse |
| fl_rd | output | 1 | Read strobe |
| fl_rdata | input | 32 | Flash read data |
| fl_ws | output | 4 | Current read wait states |
| fl_vfy_req | output | 2 | Per-bank program-verify mode request |
| fl_vfy_ack | input | 2 | Per-bank mode status |
| done | output | 1 | Burst complete |
| error | output | 1 | Burst failed |
| irq | output | 1 | Completion interrupt pulse |

## Verification
A wrong merge, an early read sample or a read taken before the mode acknowledge all corrupt the working word. The fault shows at the ports within the same burst: `fl_prog` pulse counts per word change, and the final flash contents differ from the targets. A wrong pass counter or limit test changes the `error` outcome and the number of pulses at `done`. A wrong bank mask leaves a bank in normal mode, so words there verify too early and receive too few pulses. The flash model reads 0 for any sample taken before the configured wait states have passed, so wait-state errors show up as false completions.

// File: rtl/fbps_pkg.sv
package fbps_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE_WAIT,
        S_PRE_RD,
        S_CHECK,
        S_PROG,
        S_VFY_WS,
        S_VFY_REQ,
        S_VFY_WAIT,
        S_VFY_RD,
        S_NRM_REQ,
        S_NRM_WAIT
    } seq_state_e;

endpackage

// File: rtl/fbps_merge.sv
module fbps_merge #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] flash_word,
    input  logic [DW-1:0] cur_word,
    output logic [DW-1:0] next_word,
    output logic          word_done
);

    logic [DW-1:0] settled;

    always_comb begin
        settled   = ~(flash_word | cur_word);
        next_word = cur_word | settled;
        word_done = &cur_word;
    end

endmodule

// File: rtl/fbps_bank_map.sv
module fbps_bank_map #(
    parameter int AW = 16,
    parameter int IW = 2
) (
    input  logic [AW-1:0] base,
    input  logic [IW-1:0] last,
    input  logic [AW-1:0] limit,
    output logic [1:0]    mask
);

    logic [AW-1:0] end_addr;

    always_comb begin
        end_addr = base + AW'(last);
        mask[0]  = (base < limit) || (end_addr < limit);
        mask[1]  = (base >= limit) || (end_addr >= limit);
    end

endmodule

// File: rtl/flash_burst_prog_seq.sv
module flash_burst_prog_seq
    import fbps_pkg::*;
#(
    parameter int DW  = 32,
    parameter int NW  = 4,
    parameter int AW  = 16,
    parameter int CW  = 4,
    parameter int WSW = 4,
    localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_en,
    input  logic [IW-1:0]  ld_idx,
    input  logic [DW-1:0]  ld_word,
    input  logic           start,
    input  logic [IW-1:0]  burst_len,
    input  logic [AW-1:0]  base_addr,
    input  logic           pre_check_en,
    input  logic [CW-1:0]  max_pulses,
    input  logic [WSW-1:0] ws_normal,
    input  logic [WSW-1:0] ws_verify,
    input  logic [AW-1:0]  bank_limit,
    input  logic           irq_en,
    output logic [AW-1:0]  fl_addr,
    output logic [DW-1:0]  fl_wdata,
    output logic           fl_prog,
    output logic           fl_rd,
    input  logic [DW-1:0]  fl_rdata,
    output logic [WSW-1:0] fl_ws,
    output logic [1:0]     fl_vfy_req,
    input  logic [1:0]     fl_vfy_ack,
    output logic           done,
    output logic           error,
    output logic           irq
);

    typedef struct packed {
        seq_state_e            st;
        logic [IW-1:0]         idx;
        logic [IW-1:0]         last;
        logic [AW-1:0]         base;
        logic [CW-1:0]         pass;
        logic [CW-1:0]         maxp;
        logic [WSW-1:0]        wcnt;
        logic [WSW-1:0]        ws;
        logic [1:0]            vreq;
        logic                  done;
        logic                  err;
        logic                  irq;
        logic [NW-1:0][DW-1:0] data;
    } ctx_t;

    ctx_t c_q, c_d;

    logic [NW-1:0][DW-1:0] merged;
    logic [NW-1:0]         wdone;
    logic [NW-1:0]         in_burst;
    logic                  all_done;
    logic [1:0]            bank_mask;

    for (genvar g = 0; g < NW; g++) begin : g_word
        fbps_merge #(.DW(DW)) u_merge (
            .flash_word (fl_rdata),
            .cur_word   (c_q.data[g]),
            .next_word  (merged[g]),
            .word_done  (wdone[g])
        );
        assign in_burst[g] = (IW'(g) <= c_q.last);
    end

    assign all_done = &(wdone | ~in_burst);

    fbps_bank_map #(.AW(AW), .IW(IW)) u_bank (
        .base  (c_q.base),
        .last  (c_q.last),
        .limit (bank_limit),
        .mask  (bank_mask)
    );

    always_comb begin
        c_d     = c_q;
        c_d.irq = 1'b0;
        case (c_q.st)
            S_IDLE: begin
                if (ld_en) c_d.data[ld_idx] = ld_word;
                if (start) begin
                    c_d.base = base_addr;
                    c_d.last = burst_len;
                    c_d.maxp = max_pulses;
                    c_d.pass = '0;
                    c_d.idx  = '0;
                    c_d.done = 1'b0;
                    c_d.err  = 1'b0;
                    c_d.ws   = ws_normal;
                    c_d.st   = pre_check_en ? S_PRE_WAIT : S_CHECK;
                end
            end
            S_PRE_WAIT: begin
                c_d.wcnt = c_q.ws;
                if (fl_vfy_ack == 2'b00) c_d.st = S_PRE_RD;
            end
            S_PRE_RD, S_VFY_RD: begin
                if (c_q.wcnt != '0) begin
                    c_d.wcnt = c_q.wcnt - WSW'(1);
                end else begin
                    c_d.data[c_q.idx] = merged[c_q.idx];
                    c_d.wcnt = c_q.ws;
                    if (c_q.idx == c_q.last) begin
                        c_d.idx = '0;
                        c_d.st  = (c_q.st == S_PRE_RD) ? S_CHECK : S_NRM_REQ;
                    end else begin
                        c_d.idx = c_q.idx + IW'(1);
                    end
                end
            end
            S_CHECK: begin
                c_d.idx = '0;
                if (all_done) begin
                    c_d.done = 1'b1;
                    c_d.irq  = irq_en;
                    c_d.st   = S_IDLE;
                end else if (c_q.pass == c_q.maxp) begin
                    c_d.done = 1'b1;
                    c_d.err  = 1'b1;
                    c_d.irq  = irq_en;
                    c_d.st   = S_IDLE;
                end else begin
                    c_d.pass = c_q.pass + CW'(1);
                    c_d.st   = S_PROG;
                end
            end
            S_PROG: begin
                if (c_q.idx == c_q.last) begin
                    c_d.idx = '0;
                    c_d.st  = S_VFY_WS;
                end else begin
                    c_d.idx = c_q.idx + IW'(1);
                end
            end
            S_VFY_WS: begin
                c_d.ws = ws_verify;
                c_d.st = S_VFY_REQ;
            end
            S_VFY_REQ: begin
                c_d.vreq = bank_mask;
                c_d.st   = S_VFY_WAIT;
            end
            S_VFY_WAIT: begin
                c_d.wcnt = c_q.ws;
                c_d.idx  = '0;
                if (fl_vfy_ack == c_q.vreq) c_d.st = S_VFY_RD;
            end
            S_NRM_REQ: begin
                c_d.vreq = 2'b00;
                c_d.st   = S_NRM_WAIT;
            end
            S_NRM_WAIT: begin
                if (fl_vfy_ack == 2'b00) begin
                    c_d.ws = ws_normal;
                    c_d.st = S_CHECK;
                end
            end
            default: c_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= S_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign fl_addr    = c_q.base + AW'(c_q.idx);
    assign fl_wdata   = c_q.data[c_q.idx];
    assign fl_prog    = (c_q.st == S_PROG) && !wdone[c_q.idx];
    assign fl_rd      = (c_q.st == S_PRE_RD) || (c_q.st == S_VFY_RD);
    assign fl_ws      = c_q.ws;
    assign fl_vfy_req = c_q.vreq;
    assign done       = c_q.done;
    assign error      = c_q.err;
    assign irq        = c_q.irq;

    AST_RD_MODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rd |-> (fl_vfy_ack == fl_vfy_req)); // R4
    AST_VFY_WAIT_STATES: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_rd && fl_vfy_req != 2'b00) |-> (fl_ws == ws_verify)); // R4
    AST_PROG_IN_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        fl_prog |-> (fl_vfy_req == 2'b00 && fl_vfy_ack == 2'b00)); // R5
    AST_PASS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st != S_IDLE) |-> (c_q.pass <= c_q.maxp)); // R6
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R8
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done); // R8
    AST_DATA_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st != S_IDLE && $past(c_q.st) != S_IDLE)
            |-> (($past(c_q.data) & ~c_q.data) == '0)); // R2

endmodule

// File: tb/flash_burst_prog_seq_test.sv
`timescale 1ns/1ps
module flash_burst_prog_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_idx = '0;
    logic [31:0] ld_word = '0;
    logic        start = 1'b0;
    logic [1:0]  burst_len = '0;
    logic [15:0] base_addr = '0;
    logic        pre_check_en = 1'b0;
    logic [3:0]  max_pulses = '0;
    logic [3:0]  ws_normal = '0;
    logic [3:0]  ws_verify = '0;
    logic [15:0] bank_limit = '0;
    logic        irq_en = 1'b0;
    logic [15:0] fl_addr;
    logic [31:0] fl_wdata;
    logic        fl_prog;
    logic        fl_rd;
    logic [31:0] fl_rdata;
    logic [3:0]  fl_ws;
    logic [1:0]  fl_vfy_req;
    logic [1:0]  fl_vfy_ack;
    logic        done;
    logic        error;
    logic        irq;

    always #4 clk = ~clk;

    flash_burst_prog_seq uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_word(ld_word),
        .start(start), .burst_len(burst_len), .base_addr(base_addr),
        .pre_check_en(pre_check_en), .max_pulses(max_pulses), .ws_normal(ws_normal),
        .ws_verify(ws_verify), .bank_limit(bank_limit), .irq_en(irq_en),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_prog(fl_prog), .fl_rd(fl_rd),
        .fl_rdata(fl_rdata), .fl_ws(fl_ws), .fl_vfy_req(fl_vfy_req),
        .fl_vfy_ack(fl_vfy_ack), .done(done), .error(error), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;

    // plan of the current run
    logic [31:0] tgt_a [4];
    logic [31:0] pre_a [4];
    int          need_a [4];
    int          nw_run = 1;
    logic [15:0] run_base = '0;
    logic        arm = 1'b0;

    // flash model state
    int          cnt [4][32];
    int          pulses_w [4];
    int          bad_prog;
    int          bad_rd;
    int          irq_cnt;
    logic [1:0]  seen_req;
    logic [1:0]  ack_q;
    int          dly;
    int          rd_run;
    logic        rd_q;
    logic [15:0] addr_q;

    assign fl_vfy_ack = ack_q;

    always @(posedge clk) begin
        if (arm) begin
            for (int w = 0; w < 4; w++) begin
                pulses_w[w] = 0;
                for (int b = 0; b < 32; b++) cnt[w][b] = pre_a[w][b] ? 15 : 0;
            end
            bad_prog = 0; bad_rd = 0; irq_cnt = 0; seen_req = 2'b00;
        end
        if (!rst_n) begin
            ack_q <= 2'b00; dly <= 0; rd_run <= 0; rd_q <= 1'b0; addr_q <= '0;
        end else begin
            if (fl_vfy_req != ack_q) begin
                if (dly == 0) ack_q <= fl_vfy_req;
                else dly <= dly - 1;
            end else begin
                dly <= int'($urandom % 5);
            end
            if (fl_rd) begin
                if (rd_q && fl_addr == addr_q) rd_run <= rd_run + 1;
                else rd_run <= 1;
            end else begin
                rd_run <= 0;
            end
            rd_q   <= fl_rd;
            addr_q <= fl_addr;
            if (fl_prog) begin
                int off;
                off = int'(fl_addr) - int'(run_base);
                if (off < 0 || off >= nw_run || fl_wdata == 32'hFFFF_FFFF) begin
                    bad_prog = bad_prog + 1;
                end else begin
                    pulses_w[off] = pulses_w[off] + 1;
                    for (int b = 0; b < 32; b++)
                        if (!fl_wdata[b] && cnt[off][b] < 15) cnt[off][b] = cnt[off][b] + 1;
                end
            end
            if (fl_rd && ack_q != fl_vfy_req) bad_rd = bad_rd + 1;
            if (irq) irq_cnt = irq_cnt + 1;
            seen_req = seen_req | fl_vfy_req;
        end
    end

    always_comb begin
        int  off;
        int  eff;
        int  thr;
        logic vm;
        off = int'(fl_addr) - int'(run_base);
        eff = (rd_q && fl_addr == addr_q) ? rd_run : 0;
        vm  = (fl_addr >= bank_limit) ? ack_q[1] : ack_q[0];
        thr = vm ? int'(ws_verify) : int'(ws_normal);
        fl_rdata = '0;
        if (fl_rd && off >= 0 && off < nw_run && eff >= thr)
            for (int b = 0; b < 32; b++)
                fl_rdata[b] = !(cnt[off][b] >= (vm ? need_a[off] : 1));
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int need_eff(input int w, input bit pre);
        logic [31:0] zeros;
        logic [31:0] fresh;
        zeros = ~tgt_a[w];
        fresh = zeros & ~pre_a[w];
        if (fresh != 0) return need_a[w];
        if (!pre && zeros != 0) return 1;
        return 0;
    endfunction

    function automatic logic [1:0] exp_mask(input int base, input int n, input int lim);
        logic [1:0] m;
        m = 2'b00;
        m |= (base >= lim) ? 2'b10 : 2'b01;
        m |= ((base + n - 1) >= lim) ? 2'b10 : 2'b01;
        return m;
    endfunction

    task automatic do_run(input int n, input bit pre, input int maxp, input int wsn,
                          input int wsv, input int base, input int lim, input bit ie,
                          input bit disturb);
        int  m_need;
        int  waited;
        bit  exp_fail;
        @(negedge clk);
        nw_run = n; run_base = 16'(base);
        burst_len = 2'(n - 1); base_addr = 16'(base); pre_check_en = pre;
        max_pulses = 4'(maxp); ws_normal = 4'(wsn); ws_verify = 4'(wsv);
        bank_limit = 16'(lim); irq_en = ie;
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        for (int w = 0; w < n; w++) begin
            ld_en = 1'b1; ld_idx = 2'(w); ld_word = tgt_a[w];
            @(negedge clk);
        end
        ld_en = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            repeat (6) @(negedge clk);
            chk("R1", "busy at disturbance", longint'(done), 0);
            ld_en = 1'b1; ld_idx = 2'd0; ld_word = 32'h0000_0000;
            start = 1'b1; max_pulses = 4'd0;
            @(negedge clk);
            ld_en = 1'b0; start = 1'b0; max_pulses = 4'(maxp);
        end
        waited = 0;
        while (!done && waited < 4000) begin
            @(negedge clk);
            waited++;
        end
        chk("R8", "done reached", longint'(done), 1);
        repeat (2) @(negedge clk);
        m_need = 0;
        for (int w = 0; w < n; w++) if (need_eff(w, pre) > m_need) m_need = need_eff(w, pre);
        exp_fail = (m_need > maxp);
        chk(disturb ? "R1" : "R6", "error outcome", longint'(error), longint'(exp_fail));
        chk("R8", "irq pulse count", irq_cnt, ie ? 1 : 0);
        for (int w = 0; w < n; w++) begin
            int e;
            e = need_eff(w, pre);
            if (e > maxp) e = maxp;
            chk(pre ? "R3" : "R6", $sformatf("pulses word %0d", w), pulses_w[w], e);
        end
        chk("R2", "pulse on finished word or bad address", bad_prog, 0);
        chk("R4", "read before mode acknowledge", bad_rd, 0);
        chk("R7", "bank mask", longint'(seen_req),
            (m_need > 0 && maxp > 0) ? longint'(exp_mask(base, n, lim)) : 0);
        chk("R5", "mode request idle at end", longint'(fl_vfy_req), 0);
        chk("R5", "normal wait states at end", longint'(fl_ws), wsn);
        if (!exp_fail) begin
            int wrong;
            wrong = 0;
            for (int w = 0; w < n; w++)
                for (int b = 0; b < 32; b++)
                    if ((cnt[w][b] >= 1) != !tgt_a[w][b]) wrong++;
            chk(disturb ? "R1" : "R2", "final flash bit errors", wrong, 0);
        end
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    task automatic rand_plan(input int n);
        for (int w = 0; w < 4; w++) begin
            tgt_a[w] = (($urandom % 5) == 0) ? 32'hFFFF_FFFF : $urandom;
            pre_a[w] = ~tgt_a[w] & $urandom;
            need_a[w] = 1 + int'($urandom % 3);
        end
        if (n < 1) tgt_a[0] = 32'hFFFF_FFFF;
    endtask

    initial begin
        void'($urandom(32'd2718));
        for (int w = 0; w < 4; w++) begin
            tgt_a[w] = '1; pre_a[w] = '0; need_a[w] = 1;
        end
        arm = 1'b1;
        repeat (3) @(negedge clk);
        arm = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "done after reset", longint'(done), 0);
        chk("R9", "error after reset", longint'(error), 0);
        chk("R9", "irq after reset", longint'(irq), 0);
        chk("R9", "prog after reset", longint'(fl_prog), 0);
        chk("R9", "read after reset", longint'(fl_rd), 0);
        chk("R9", "mode request after reset", longint'(fl_vfy_req), 0);

        // R3: every target zero already programmed, pre-check masks all
        for (int w = 0; w < 4; w++) begin
            tgt_a[w] = 32'h0F0F_A5A5 ^ 32'(w); pre_a[w] = ~tgt_a[w]; need_a[w] = 2;
        end
        do_run(4, 1'b1, 3, 2, 3, 16'h0100, 16'h8000, 1'b1, 1'b0);
        // same contents without pre-check: one pass each
        do_run(4, 1'b0, 3, 1, 4, 16'h0100, 16'h8000, 1'b0, 1'b0);

        // R6: zero limit fails with no pulse
        for (int w = 0; w < 4; w++) begin
            tgt_a[w] = 32'hFFFF_0000; pre_a[w] = '0; need_a[w] = 1;
        end
        do_run(2, 1'b0, 0, 0, 0, 16'h0200, 16'h8000, 1'b1, 1'b0);
        // R6: limit boundary, needs 3
        for (int w = 0; w < 4; w++) begin
            tgt_a[w] = 32'h1234_5678 + 32'(w); pre_a[w] = '0; need_a[w] = 3;
        end
        do_run(4, 1'b1, 3, 3, 5, 16'h0300, 16'h8000, 1'b0, 1'b0);
        do_run(4, 1'b1, 2, 3, 5, 16'h0300, 16'h8000, 1'b1, 1'b0);

        // R7: burst crossing the bank limit, and fully in the upper bank
        for (int w = 0; w < 4; w++) begin
            tgt_a[w] = 32'h8000_0001 ^ (32'(w) << 8); pre_a[w] = '0; need_a[w] = 1 + w % 3;
        end
        do_run(4, 1'b0, 4, 1, 6, 16'h3FFE, 16'h4000, 1'b0, 1'b0);
        do_run(3, 1'b0, 4, 0, 2, 16'h5000, 16'h4000, 1'b0, 1'b0);

        // R1: start and load while busy are ignored
        for (int w = 0; w < 4; w++) begin
            tgt_a[w] = 32'hFFFF_FFF0; pre_a[w] = '0; need_a[w] = 2;
        end
        do_run(4, 1'b0, 3, 2, 2, 16'h0400, 16'h8000, 1'b1, 1'b1);

        for (int k = 0; k < 40; k++) begin
            int n;
            int base;
            int lim;
            n = 1 + int'($urandom % 4);
            rand_plan(n);
            base = int'($urandom % 16'hFF00);
            lim  = (($urandom % 2) == 0) ? base + int'($urandom % 5) : int'($urandom % 16'hFFFF);
            if (lim > 16'hFFFF) lim = 16'hFFFF;
            do_run(n, 1'(($urandom) % 2), int'($urandom % 5), int'($urandom % 7),
                   int'($urandom % 7), base, lim, 1'(($urandom) % 2), 1'b0);
        end
        finish_up();
    end

endmodule